// File: doc/BRIEF.md
# Multi-lane sample word generator

This block produces a stream of 64-bit test words for a streaming link that has two or more lanes. On every cycle that carries data it presents one word per lane. Each word holds a lane identifier, a running burst number and a running word number. A receiver that knows this layout can confirm two things: that the lanes were aligned to each other, and that no word or burst was lost or reordered.

The output side is a source user interface with a valid strobe and with start-of-burst and end-of-burst markers. The length of each burst and the number of idle cycles between bursts come from run-time configuration inputs. These inputs are captured when a burst starts. An enable input controls whether new bursts may begin. A burst that has already started always runs to its last word.

The word number runs on across burst boundaries. The burst number moves up only when a new burst starts. Because of this, a checker can tell a skipped word apart from a skipped burst.

Top module: `lane_sample_gen`

## Requirements
- R1: Lane l occupies tx_data[64*l+63 : 64*l]. Within each lane word, bits 63:59 hold the lane ID, which is ID_BASE plus l (5-bit wrap). Bits 58:32 hold the burst number and bits 31:0 hold the word number.
- R2: While reset is held, tx_valid, tx_sob and tx_eob are 0, every lane shows burst number 1, and every lane shows word number 0.
- R3: The first burst after reset carries burst number 1. Each later burst carries the previous burst's number plus one. The burst number stays constant across all words of a burst.
- R4: Each valid word carries the word number of the previous valid word plus one, also across burst boundaries. The first valid word after reset carries 1.
- R5: On cycles with tx_valid low, the burst number and word number do not change.
- R6: On every cycle, all lanes carry the same burst number and word number.
- R7: A burst is a run of consecutive valid cycles. Its first word has tx_sob set and its last word has tx_eob set. It holds exactly cfg_burst_len words, and a length of 0 gives one word with both markers set. tx_sob and tx_eob are never set without tx_valid.
- R8: While enable stays high, exactly cfg_gap idle cycles separate an end-of-burst word from the next start-of-burst word. A gap of 0 gives back-to-back bursts.
- R9: cfg_burst_len and cfg_gap are captured at the start of a burst. Changing them during the burst has no effect on that burst's length or on the gap that follows it.
- R10: A burst starts only when enable is sampled high while the block is idle and the gap has expired. Its first word appears on the cycle after that sampling edge. When enable drops mid-burst, the burst still completes, and no further burst starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Allows new bursts to start |
| cfg_burst_len | input | LEN_W | Words per burst; 0 is treated as 1 |
| cfg_gap | input | GAP_W | Idle cycles after each burst |
| tx_valid | output | 1 | A word is present on every lane |
| tx_sob | output | 1 | First word of a burst |
| tx_eob | output | 1 | Last word of a burst |
| tx_data | output | LANES*64 | One 64-bit sample word per lane |

## Verification
Every output is registered. A start decision taken at a rising edge therefore shows up as tx_sob and the new field values in the cycle that follows that edge. The word number then rises by one on each later valid cycle. After the end-of-burst word, exactly cfg_gap cycles with tx_valid low pass before the next start-of-burst word. The bench drives inputs and reads outputs 1 ns after each falling edge. It records the cycle index of every start and end marker, so that burst lengths, gaps and the one-cycle start latency are computed as differences between those indices rather than by timing guesses.

// File: rtl/lane_sample_pkg.sv
package lane_sample_pkg;
  localparam int WORD_W = 64;
  localparam int ID_W   = 5;
  localparam int BC_W   = 27;
  localparam int WC_W   = 32;
  localparam int WC_LSB = 0;
  localparam int BC_LSB = WC_LSB + WC_W;
  localparam int ID_LSB = BC_LSB + BC_W;

  typedef enum logic {FR_IDLE, FR_BURST} fr_state_t;

  function automatic logic [WORD_W-1:0] pack_word(input logic [ID_W-1:0] id,
                                                  input logic [BC_W-1:0] bc,
                                                  input logic [WC_W-1:0] wc);
    return {id, bc, wc};
  endfunction

  function automatic logic [ID_W-1:0] lane_id(input logic [ID_W-1:0] base,
                                               input int unsigned lane);
    return base + ID_W'(lane);
  endfunction

  function automatic logic [BC_W-1:0] bump_bc(input logic [BC_W-1:0] v);
    return v + BC_W'(1);
  endfunction

  function automatic logic [WC_W-1:0] bump_wc(input logic [WC_W-1:0] v);
    return v + WC_W'(1);
  endfunction
endpackage

// File: rtl/burst_framer.sv
module burst_framer
  import lane_sample_pkg::*;
#(
  parameter int LEN_W = 8,
  parameter int GAP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [LEN_W-1:0] cfg_len,
  input  logic [GAP_W-1:0] cfg_gap,
  output logic             valid_q,
  output logic             sob_q,
  output logic             eob_q,
  output logic             burst_start,
  output logic             word_adv
);
  fr_state_t        state;
  logic [LEN_W-1:0] remain;
  logic [GAP_W-1:0] gap_cnt;
  logic [GAP_W-1:0] gap_lat;
  logic [LEN_W-1:0] eff_len;
  logic             gap_done;
  logic             last_now;

  always_comb begin
    eff_len     = (cfg_len == '0) ? LEN_W'(1) : cfg_len;
    gap_done    = (gap_cnt == '0);
    burst_start = (state == FR_IDLE) && gap_done && enable;
    word_adv    = burst_start || (state == FR_BURST);
    if (burst_start) last_now = (eff_len == LEN_W'(1));
    else             last_now = (state == FR_BURST) && (remain == LEN_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= FR_IDLE;
      remain  <= '0;
      gap_cnt <= '0;
      gap_lat <= '0;
      valid_q <= 1'b0;
      sob_q   <= 1'b0;
      eob_q   <= 1'b0;
    end else begin
      valid_q <= word_adv;
      sob_q   <= burst_start;
      eob_q   <= word_adv && last_now;
      case (state)
        FR_IDLE: begin
          if (!gap_done) begin
            gap_cnt <= gap_cnt - GAP_W'(1);
          end else if (enable) begin
            gap_lat <= cfg_gap;
            remain  <= eff_len - LEN_W'(1);
            if (eff_len == LEN_W'(1)) gap_cnt <= cfg_gap;
            else                      state   <= FR_BURST;
          end
        end
        FR_BURST: begin
          remain <= remain - LEN_W'(1);
          if (remain == LEN_W'(1)) begin
            state   <= FR_IDLE;
            gap_cnt <= gap_lat;
          end
        end
        default: state <= FR_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sample_counters.sv
module sample_counters
  import lane_sample_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            burst_start,
  input  logic            word_adv,
  output logic [BC_W-1:0] bc_q,
  output logic [WC_W-1:0] wc_q
);
  logic [BC_W-1:0] bc_next;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bc_q    <= BC_W'(1);
      bc_next <= BC_W'(1);
      wc_q    <= '0;
    end else begin
      if (burst_start) begin
        bc_q    <= bc_next;
        bc_next <= bump_bc(bc_next);
      end
      if (word_adv) wc_q <= bump_wc(wc_q);
    end
  end
endmodule

// File: rtl/word_packer.sv
module word_packer
  import lane_sample_pkg::*;
#(
  parameter int             LANES   = 2,
  parameter logic [ID_W-1:0] ID_BASE = 5'd12
) (
  input  logic [BC_W-1:0]         bc,
  input  logic [WC_W-1:0]         wc,
  output logic [LANES*WORD_W-1:0] data
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign data[l*WORD_W +: WORD_W] = pack_word(lane_id(ID_BASE, l), bc, wc);
  end
endmodule

// File: rtl/lane_sample_gen.sv
module lane_sample_gen
  import lane_sample_pkg::*;
#(
  parameter int              LANES   = 2,
  parameter int              LEN_W   = 8,
  parameter int              GAP_W   = 8,
  parameter logic [ID_W-1:0] ID_BASE = 5'd12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     enable,
  input  logic [LEN_W-1:0]         cfg_burst_len,
  input  logic [GAP_W-1:0]         cfg_gap,
  output logic                     tx_valid,
  output logic                     tx_sob,
  output logic                     tx_eob,
  output logic [LANES*WORD_W-1:0]  tx_data
);
  logic            burst_start;
  logic            word_adv;
  logic [BC_W-1:0] bc_q;
  logic [WC_W-1:0] wc_q;

  burst_framer #(.LEN_W(LEN_W), .GAP_W(GAP_W)) u_framer (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .cfg_len(cfg_burst_len), .cfg_gap(cfg_gap),
    .valid_q(tx_valid), .sob_q(tx_sob), .eob_q(tx_eob),
    .burst_start(burst_start), .word_adv(word_adv)
  );

  sample_counters u_cnt (
    .clk(clk), .rst_n(rst_n), .burst_start(burst_start),
    .word_adv(word_adv), .bc_q(bc_q), .wc_q(wc_q)
  );

  word_packer #(.LANES(LANES), .ID_BASE(ID_BASE)) u_pack (
    .bc(bc_q), .wc(wc_q), .data(tx_data)
  );
endmodule

// File: rtl/lane_sample_gen_chk.sv
module lane_sample_gen_chk
  import lane_sample_pkg::*;
#(
  parameter int              LANES   = 2,
  parameter logic [ID_W-1:0] ID_BASE = 5'd12
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    tx_valid,
  input logic                    tx_sob,
  input logic                    tx_eob,
  input logic [LANES*WORD_W-1:0] tx_data,
  input logic                    burst_start,
  input logic                    word_adv
);
  logic [WC_W-1:0] wc0;
  logic [BC_W-1:0] bc0;
  logic            seen_sob;
  logic            in_b;

  assign wc0 = tx_data[WC_LSB +: WC_W];
  assign bc0 = tx_data[BC_LSB +: BC_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_sob <= 1'b0;
      in_b     <= 1'b0;
    end else if (tx_valid) begin
      if (tx_sob) seen_sob <= 1'b1;
      in_b <= !tx_eob;
    end
  end

  assert_word_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> wc0 == WC_W'($past(wc0) + 1));
  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_valid |-> ($stable(wc0) && $stable(bc0)));
  assert_first_burst_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_sob && !seen_sob) |-> bc0 == BC_W'(1));
  assert_burst_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_sob && seen_sob) |-> bc0 == BC_W'($past(bc0) + 1));
  assert_bc_flat_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_sob) |-> $stable(bc0));
  assert_marker_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_sob || tx_eob) |-> tx_valid);
  assert_no_hole_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_b |-> (tx_valid && !tx_sob));
  assert_open_burst_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !in_b) |-> tx_sob);
  assert_start_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    burst_start |=> tx_sob);
  assert_word_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    word_adv |=> tx_valid);

  for (genvar l = 0; l < LANES; l++) begin : g_lane_chk
    assert_lane_id_R1: assert property (@(posedge clk) disable iff (!rst_n)
      tx_data[l*WORD_W + ID_LSB +: ID_W] == ID_W'(ID_BASE + ID_W'(l)));
    assert_lane_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
      tx_data[l*WORD_W +: ID_LSB] == tx_data[0 +: ID_LSB]);
  end
endmodule

bind lane_sample_gen lane_sample_gen_chk #(.LANES(LANES), .ID_BASE(ID_BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_sob(tx_sob),
  .tx_eob(tx_eob), .tx_data(tx_data), .burst_start(burst_start),
  .word_adv(word_adv)
);

// File: tb/lane_sample_gen_tb.sv
`timescale 1ns/1ps
module lane_sample_gen_tb;
  localparam int         LANES   = 2;
  localparam logic [4:0] ID_BASE = 5'd12;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             enable = 1'b0;
  logic [7:0]       cfg_burst_len = 8'd1;
  logic [7:0]       cfg_gap = 8'd0;
  logic             tx_valid, tx_sob, tx_eob;
  logic [LANES*64-1:0] tx_data;

  always #10 clk = ~clk;

  lane_sample_gen #(.LANES(LANES), .ID_BASE(ID_BASE)) u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_burst_len(cfg_burst_len),
    .cfg_gap(cfg_gap), .tx_valid(tx_valid), .tx_sob(tx_sob), .tx_eob(tx_eob),
    .tx_data(tx_data)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // monitor: one record per negedge, bursts logged by cycle index
  int          cyc;
  logic [31:0] prev_wc;
  logic [26:0] prev_bc;
  bit          inb;
  int          cur_start;
  int          nb;
  int          bstart [64];
  int          bend   [64];
  int          blen   [64];

  always @(negedge clk) begin
    if (!rst_n) begin
      cyc = 0; prev_wc = '0; prev_bc = 27'd1; nb = 0; inb = 1'b0; cur_start = 0;
    end else begin
      logic [31:0] wc;
      logic [26:0] bc;
      cyc++;
      wc = tx_data[31:0];
      bc = tx_data[58:32];
      for (int l = 0; l < LANES; l++) begin
        chk(tx_data[l*64+59 +: 5] == 5'(ID_BASE + 5'(l)), "R1", "lane id",
            tx_data[l*64+59 +: 5], 5'(ID_BASE + 5'(l)));
        chk(tx_data[l*64 +: 59] == tx_data[58:0], "R6", "lane fields",
            tx_data[l*64 +: 32], wc);
      end
      if (tx_valid) begin
        chk(wc == prev_wc + 32'd1, "R4", "word number", wc, prev_wc + 32'd1);
        if (tx_sob) begin
          chk(bc == 27'(nb + 1), "R3", "burst number at start", bc, nb + 1);
          chk(!inb, "R7", "start inside burst", inb, 0);
          cur_start = cyc;
          inb = 1'b1;
        end else begin
          chk(bc == prev_bc, "R3", "burst number within burst", bc, prev_bc);
          chk(inb, "R7", "word outside burst", inb, 1);
        end
        if (tx_eob) begin
          if (nb < 64) begin
            bstart[nb] = cur_start; bend[nb] = cyc; blen[nb] = cyc - cur_start + 1;
          end
          nb++;
          inb = 1'b0;
        end
      end else begin
        chk(wc == prev_wc && bc == prev_bc, "R5", "idle hold", wc, prev_wc);
        chk(!inb, "R7", "hole in burst", inb, 0);
        chk(!tx_sob && !tx_eob, "R7", "marker without valid", {tx_sob, tx_eob}, 0);
      end
      prev_wc = wc;
      prev_bc = bc;
    end
  end

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic wait_bursts(input int n);
    while (nb < n) tick();
  endtask

  task automatic do_reset();
    enable = 1'b0;
    rst_n  = 1'b0;
    repeat (3) tick();
    chk(!tx_valid && !tx_sob && !tx_eob, "R2", "strobes in reset",
        {tx_valid, tx_sob, tx_eob}, 0);
    for (int l = 0; l < LANES; l++) begin
      chk(tx_data[l*64+32 +: 27] == 27'd1, "R2", "burst number in reset",
          tx_data[l*64+32 +: 27], 1);
      chk(tx_data[l*64 +: 32] == 32'd0, "R2", "word number in reset",
          tx_data[l*64 +: 32], 0);
    end
    rst_n = 1'b1;
    tick();
  endtask

  task automatic t_basic();
    do_reset();
    cfg_burst_len = 8'd4; cfg_gap = 8'd2;
    enable = 1'b1;
    tick();
    chk(tx_valid && tx_sob, "R10", "start one cycle after enable", tx_sob, 1);
    wait_bursts(3);
    enable = 1'b0;
    repeat (20) tick();
    chk(nb == 3, "R10", "no start with enable low", nb, 3);
    for (int i = 0; i < 3; i++) chk(blen[i] == 4, "R7", "burst length", blen[i], 4);
    for (int i = 0; i < 2; i++)
      chk(bstart[i+1] - bend[i] - 1 == 2, "R8", "gap", bstart[i+1] - bend[i] - 1, 2);
  endtask

  task automatic t_single();
    do_reset();
    cfg_burst_len = 8'd0; cfg_gap = 8'd0;
    enable = 1'b1;
    wait_bursts(4);
    enable = 1'b0;
    repeat (10) tick();
    for (int i = 0; i < 4; i++) chk(blen[i] == 1, "R7", "zero length as one", blen[i], 1);
    for (int i = 0; i < 3; i++)
      chk(bstart[i+1] == bend[i] + 1, "R8", "back to back", bstart[i+1], bend[i] + 1);
  endtask

  task automatic t_cfg_change();
    do_reset();
    cfg_burst_len = 8'd6; cfg_gap = 8'd3;
    enable = 1'b1;
    tick();
    cfg_burst_len = 8'd2; cfg_gap = 8'd0;
    wait_bursts(3);
    enable = 1'b0;
    repeat (10) tick();
    chk(blen[0] == 6, "R9", "length held", blen[0], 6);
    chk(bstart[1] - bend[0] - 1 == 3, "R9", "gap held", bstart[1] - bend[0] - 1, 3);
    chk(blen[1] == 2 && blen[2] == 2, "R9", "new length", blen[1], 2);
    chk(bstart[2] == bend[1] + 1, "R8", "new gap zero", bstart[2], bend[1] + 1);
  endtask

  task automatic t_enable_drop();
    do_reset();
    cfg_burst_len = 8'd10; cfg_gap = 8'd1;
    enable = 1'b1;
    repeat (3) tick();
    enable = 1'b0;
    repeat (30) tick();
    chk(nb == 1, "R10", "single burst after drop", nb, 1);
    chk(blen[0] == 10, "R10", "burst completes", blen[0], 10);
  endtask

  initial begin
    t_basic();
    t_single();
    t_cfg_change();
    t_enable_drop();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule